// File: doc/BRIEF.md
# Hit-Centred 3x3 Cluster Extractor

This block reads a raster-ordered stream of correlated-double-sampled pixel values, one pixel per accepted beat, each carrying its row, its column and a hit flag already decided by an upstream threshold stage. It keeps the two most recent rows in line buffers, so that a full 3x3 neighbourhood is available around every pixel. For each pixel flagged as a hit, it produces one record: the centre row and column plus the nine neighbourhood values. Every other pixel of the frame is discarded, which reduces the data volume to the hit regions only.

A neighbourhood is complete once the pixel one row and one column beyond the centre has arrived. The control path has three states. In `ST_RUN` the block accepts input. The transition `eol` moves from `ST_RUN` to `ST_PAD` after a last-column pixel is accepted. `ST_PAD` takes one virtual step in an extra column, so that last-column centres can close. From `ST_PAD`, the transition `next_row` returns to `ST_RUN`, or the transition `frame_end` enters `ST_FLUSH` after the final row. `ST_FLUSH` steps through one virtual row of zeros to close the bottom-row centres, and the transition `flush_done` returns to `ST_RUN`.

Finished records pass through a small FIFO to a valid/ready output. Overlapping neighbourhoods are not merged, and no centroid is computed.

Top module: `cluster3x3_finder`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and overflow is 0.
- R2: Exactly one record is produced for each accepted pixel whose in_hit is 1, and none for pixels with in_hit 0.
- R3: A record carries the centre position on out_row/out_col and nine values on out_win. Element k = 3*i + j sits at bits [DW*k+DW-1:DW*k], where i is the neighbour row (0 above, 1 centre row, 2 below) and j is the neighbour column (0 left, 1 centre, 2 right). Element 4 is the centre pixel's value.
- R4: Any neighbour lying outside the frame (row -1, row ROWS, column -1 or column COLS) is reported as 0.
- R5: Hits that touch each other each give their own full record, with overlapping values. Records leave in raster order of their centres.
- R6: After a last-column pixel (column COLS-1) of a row other than the last is accepted, in_ready is 0 for exactly one cycle.
- R7: After the pixel at (ROWS-1, COLS-1) is accepted, in_ready is 0 for exactly COLS+2 cycles. During that time the records of the last row are completed.
- R8: A record is written into the output queue at the clock edge following the step that completes its window. A real pixel (r+1, c+1) completes the window of (r, c). The pad step (column COLS) completes last-column centres, and the flush steps (row ROWS) complete last-row centres.
- R9: While out_valid is 1 and out_ready is 0, the presented record stays unchanged. Records are delivered in the order they were produced.
- R10: The output queue holds FDEPTH records. A record produced while the queue is full and not popped in that cycle is dropped, and overflow then goes to 1 and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_row | input | RW | Row of the input pixel |
| in_col | input | CW | Column of the input pixel |
| in_data | input | DW | Signed pixel value |
| in_hit | input | 1 | Pixel passed the hit threshold |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_row | output | RW | Centre row of the record |
| out_col | output | CW | Centre column of the record |
| out_win | output | 9*DW | Nine neighbourhood values, row-major |
| overflow | output | 1 | Sticky: a record was dropped on a full queue |

## Verification
The bench places hits on all four corners, on each frame edge and on the last column. A design that shifts in stale line-buffer data, or that misses the left or right wrap between rows, would show non-zero padding or neighbour values taken from the wrong row. Touching hits check that no record is lost when windows overlap. Frames with gaps and a throttled consumer check that queued records hold still and keep their order. A stalled consumer fed with every pixel as a hit checks that exactly FDEPTH records survive and that overflow rises and then stays high. In every cycle, in_ready and the output are compared with a reference model, so an extra or missing pad or flush step, or a record that arrives one cycle early or late, shows up at once.

// File: rtl/cf3_pkg.sv
package cf3_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PAD   = 2'd1,
        ST_FLUSH = 2'd2
    } cf3_state_e;

    localparam int WIN_N    = 9;
    localparam int WIN_SIDE = 3;

endpackage

// File: rtl/cf3_linebuf.sv
module cf3_linebuf #(
    parameter int COLS = 640,
    parameter int DW   = 8,
    parameter int CW   = $clog2(COLS + 1)
) (
    input  logic          clk,
    input  logic          step,
    input  logic [CW-1:0] col,
    input  logic [DW-1:0] din,
    input  logic          hin,
    output logic [DW-1:0] up2,
    output logic [DW-1:0] up1,
    output logic          hit_up1
);
    localparam int DEPTH = COLS + 1;

    logic [DW-1:0] near_mem [DEPTH];
    logic [DW-1:0] far_mem  [DEPTH];
    logic          hit_mem  [DEPTH];

    assign up1     = near_mem[col];
    assign up2     = far_mem[col];
    assign hit_up1 = hit_mem[col];

    always_ff @(posedge clk) begin
        if (step) begin
            far_mem[col]  <= near_mem[col];
            near_mem[col] <= din;
            hit_mem[col]  <= hin;
        end
    end

endmodule

// File: rtl/cf3_window.sv
module cf3_window
    import cf3_pkg::*;
#(
    parameter int COLS = 640,
    parameter int ROWS = 360,
    parameter int DW   = 8,
    parameter int CW   = $clog2(COLS + 1),
    parameter int RW   = $clog2(ROWS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [RW-1:0]       s_row,
    input  logic [CW-1:0]       s_col,
    input  logic [DW-1:0]       col_top,
    input  logic [DW-1:0]       col_mid,
    input  logic [DW-1:0]       col_bot,
    input  logic                hit_in,
    output logic                rec_valid,
    output logic [RW-1:0]       rec_row,
    output logic [CW-1:0]       rec_col,
    output logic [WIN_N*DW-1:0] rec_win
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    logic [DW-1:0] win_q [WIN_SIDE][WIN_SIDE];
    logic [DW-1:0] new_col [WIN_SIDE];
    logic          hit_ctr_q, hit_rgt_q, cand_q;
    logic [RW-1:0] cr_q;
    logic [CW-1:0] cc_q;

    assign new_col[0] = col_top;
    assign new_col[1] = col_mid;
    assign new_col[2] = col_bot;

    always_ff @(posedge clk) begin
        if (step) begin
            for (int i = 0; i < WIN_SIDE; i++) begin
                win_q[i][0] <= win_q[i][1];
                win_q[i][1] <= win_q[i][2];
                win_q[i][2] <= new_col[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= 1'b0;
            hit_ctr_q <= 1'b0;
            hit_rgt_q <= 1'b0;
            cr_q      <= '0;
            cc_q      <= '0;
        end else begin
            cand_q <= step && (s_row != '0) && (s_col != '0);
            if (step) begin
                hit_ctr_q <= hit_rgt_q;
                hit_rgt_q <= hit_in;
                cr_q      <= s_row - RW'(1);
                cc_q      <= s_col - CW'(1);
            end
        end
    end

    assign rec_valid = cand_q && hit_ctr_q;
    assign rec_row   = cr_q;
    assign rec_col   = cc_q;

    for (genvar gi = 0; gi < WIN_SIDE; gi++) begin : g_row
        for (genvar gj = 0; gj < WIN_SIDE; gj++) begin : g_col
            logic outside;
            always_comb begin
                outside = 1'b0;
                if (gi == 0 && cr_q == '0)       outside = 1'b1;
                if (gi == 2 && cr_q == LAST_ROW) outside = 1'b1;
                if (gj == 0 && cc_q == '0)       outside = 1'b1;
                if (gj == 2 && cc_q == LAST_COL) outside = 1'b1;
            end
            assign rec_win[DW*(WIN_SIDE*gi+gj) +: DW] = outside ? '0 : win_q[gi][gj];
        end
    end

    // R2: a produced record always names a centre inside the frame
    p_rec_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> ((rec_row < RW'(ROWS)) && (rec_col < CW'(COLS))));

endmodule

// File: rtl/cf3_fifo.sv
module cf3_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         overflow
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]   LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT  = CNTW'(DEPTH);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wr_q, rd_q;
    logic [CNTW-1:0] cnt_q;
    logic            ovf_q;
    logic            do_pop, do_push, full;

    assign full      = (cnt_q == FULL_CNT);
    assign out_valid = (cnt_q != '0);
    assign out_data  = mem[rd_q];
    assign overflow  = ovf_q;
    assign do_pop    = out_valid && out_ready;
    assign do_push   = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST_SLOT) ? '0 : wr_q + AW'(1);
            if (do_pop)  rd_q <= (rd_q == LAST_SLOT) ? '0 : rd_q + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNTW'(1);
                2'b01:   cnt_q <= cnt_q - CNTW'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (push && full && !do_pop) ovf_q <= 1'b1;
        end
    end

    // R9: a stalled record is held unchanged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: overflow never clears without reset
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R10: occupancy stays within the queue depth
    p_count_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

endmodule

// File: rtl/cluster3x3_finder.sv
module cluster3x3_finder
    import cf3_pkg::*;
#(
    parameter int COLS   = 640,
    parameter int ROWS   = 360,
    parameter int DW     = 8,
    parameter int FDEPTH = 4,
    localparam int CW    = $clog2(COLS + 1),
    localparam int RW    = $clog2(ROWS + 1),
    localparam int WINW  = WIN_N * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [RW-1:0]   in_row,
    input  logic [CW-1:0]   in_col,
    input  logic [DW-1:0]   in_data,
    input  logic            in_hit,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [RW-1:0]   out_row,
    output logic [CW-1:0]   out_col,
    output logic [WINW-1:0] out_win,
    output logic            overflow
);
    localparam int RECW = RW + CW + WINW;
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
    localparam logic [CW-1:0] PAD_COL  = CW'(COLS);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [RW-1:0] PAD_ROW  = RW'(ROWS);

    cf3_state_e    state_q, state_d;
    logic [RW-1:0] row_q;
    logic          last_q;
    logic [CW-1:0] fcol_q;

    logic          step, s_hit;
    logic [RW-1:0] s_row;
    logic [CW-1:0] s_col;
    logic [DW-1:0] s_val;

    // next state: eol, next_row, frame_end, flush_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (in_valid && in_col == LAST_COL) state_d = ST_PAD;
            ST_PAD:   state_d = last_q ? ST_FLUSH : ST_RUN;
            ST_FLUSH: if (fcol_q == PAD_COL) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            last_q <= 1'b0;
            fcol_q <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: if (in_valid && in_col == LAST_COL) begin
                    row_q  <= in_row;
                    last_q <= (in_row == LAST_ROW);
                end
                ST_PAD:   fcol_q <= '0;
                ST_FLUSH: fcol_q <= fcol_q + CW'(1);
                default: ;
            endcase
        end
    end

    // step source per state
    always_comb begin
        in_ready = 1'b0;
        step     = 1'b0;
        s_row    = in_row;
        s_col    = in_col;
        s_val    = in_data;
        s_hit    = in_hit;
        unique case (state_q)
            ST_RUN: begin
                in_ready = 1'b1;
                step     = in_valid;
            end
            ST_PAD: begin
                step  = 1'b1;
                s_row = row_q;
                s_col = PAD_COL;
                s_val = '0;
                s_hit = 1'b0;
            end
            ST_FLUSH: begin
                step  = 1'b1;
                s_row = PAD_ROW;
                s_col = fcol_q;
                s_val = '0;
                s_hit = 1'b0;
            end
            default: ;
        endcase
    end

    logic [DW-1:0] up2, up1;
    logic          hit_up1;

    cf3_linebuf #(.COLS(COLS), .DW(DW), .CW(CW)) u_lines (
        .clk    (clk),
        .step   (step),
        .col    (s_col),
        .din    (s_val),
        .hin    (s_hit),
        .up2    (up2),
        .up1    (up1),
        .hit_up1(hit_up1)
    );

    logic            rec_valid;
    logic [RW-1:0]   rec_row;
    logic [CW-1:0]   rec_col;
    logic [WINW-1:0] rec_win;

    cf3_window #(.COLS(COLS), .ROWS(ROWS), .DW(DW), .CW(CW), .RW(RW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .s_row    (s_row),
        .s_col    (s_col),
        .col_top  (up2),
        .col_mid  (up1),
        .col_bot  (s_val),
        .hit_in   (hit_up1),
        .rec_valid(rec_valid),
        .rec_row  (rec_row),
        .rec_col  (rec_col),
        .rec_win  (rec_win)
    );

    logic [RECW-1:0] head;

    cf3_fifo #(.W(RECW), .DEPTH(FDEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rec_valid),
        .push_data({rec_row, rec_col, rec_win}),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (head),
        .overflow (overflow)
    );

    assign {out_row, out_col, out_win} = head;

    // R6: accepting a last-column pixel stalls input in the next cycle
    p_pad_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_col == LAST_COL) |=> !in_ready);

    // R4: left padding of a first-column centre is zero
    p_left_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_col == '0) |->
        ((out_win[0 +: DW] == '0) && (out_win[3*DW +: DW] == '0) && (out_win[6*DW +: DW] == '0)));

    // R4: top padding of a first-row centre is zero
    p_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row == '0) |-> (out_win[3*DW-1:0] == '0));

endmodule

// File: tb/cluster3x3_finder_bench.sv
module cluster3x3_finder_bench;
    localparam int COLS = 6, ROWS = 4, DW = 8, FDEPTH = 4;
    localparam int CW = $clog2(COLS + 1), RW = $clog2(ROWS + 1), WINW = 9 * DW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n, in_valid, in_ready, in_hit, out_valid, out_ready, overflow;
    logic [RW-1:0]   in_row, out_row;
    logic [CW-1:0]   in_col, out_col;
    logic [DW-1:0]   in_data;
    logic [WINW-1:0] out_win;

    cluster3x3_finder #(.COLS(COLS), .ROWS(ROWS), .DW(DW), .FDEPTH(FDEPTH)) u_cluster3x3_finder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .in_col(in_col), .in_data(in_data), .in_hit(in_hit),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
        .out_col(out_col), .out_win(out_win), .overflow(overflow)
    );

    int total = 0, bad = 0, cyc = 0, rdy_mode = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // reference model state
    int m_mode = 0, m_prow = 0, m_fcnt = 0, pops = 0;
    bit m_last = 0, m_ovf = 0, model_on = 0;
    int fv [ROWS][COLS];
    bit fh [ROWS][COLS];
    logic [RW-1:0]   q_row [$];
    logic [CW-1:0]   q_col [$];
    logic [WINW-1:0] q_win [$];
    bit              pend_v = 0;
    logic [RW-1:0]   pend_row;
    logic [CW-1:0]   pend_col;
    logic [WINW-1:0] pend_win;
    bit              prev_stall = 0;
    logic [WINW-1:0] prev_win;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin : model
        bit st, do_pop, push_now, drop;
        int R, C, pr, pc, val;
        logic [RW-1:0]   nrow;
        logic [CW-1:0]   ncol;
        logic [WINW-1:0] nwin, w;
        if (model_on) begin
            chk(in_ready == (m_mode == 0), "R6 R7 in_ready", in_ready, m_mode == 0);
            chk(out_valid == (q_row.size() > 0), "R2 R8 out_valid", out_valid, q_row.size() > 0);
            if (out_valid && q_row.size() > 0) begin
                chk(out_row == q_row[0], "R3 out_row", out_row, q_row[0]);
                chk(out_col == q_col[0], "R3 out_col", out_col, q_col[0]);
                chk(out_win == q_win[0], "R3 R4 R5 out_win", out_win, q_win[0]);
            end
            if (prev_stall) chk(out_valid && out_win == prev_win, "R9 hold", out_win, prev_win);
            chk(overflow == m_ovf, "R10 overflow", overflow, m_ovf);
            prev_stall = out_valid && !out_ready;
            prev_win   = out_win;

            do_pop   = (q_row.size() > 0) && out_ready;
            push_now = pend_v;
            nrow = pend_row; ncol = pend_col; nwin = pend_win;
            pend_v = 0;

            st = 0; R = 0; C = 0;
            if (m_mode == 0) begin
                if (in_valid) begin
                    st = 1; R = int'(in_row); C = int'(in_col);
                    fv[R][C] = int'($signed(in_data));
                    fh[R][C] = in_hit;
                    if (C == COLS - 1) begin
                        m_mode = 1; m_prow = R; m_last = (R == ROWS - 1);
                    end
                end
            end else if (m_mode == 1) begin
                st = 1; R = m_prow; C = COLS;
                m_mode = m_last ? 2 : 0; m_fcnt = 0;
            end else begin
                st = 1; R = ROWS; C = m_fcnt;
                if (m_fcnt == COLS) m_mode = 0;
                else m_fcnt++;
            end

            if (st && R >= 1 && C >= 1 && fh[R-1][C-1]) begin
                w = '0;
                for (int i = 0; i < 3; i++)
                    for (int j = 0; j < 3; j++) begin
                        pr = R - 2 + i; pc = C - 2 + j;
                        val = (pr >= 0 && pr < ROWS && pc >= 0 && pc < COLS) ? fv[pr][pc] : 0;
                        w[(3*i+j)*DW +: DW] = val[DW-1:0];
                    end
                pend_v = 1; pend_row = RW'(R - 1); pend_col = CW'(C - 1); pend_win = w;
            end

            drop = push_now && (q_row.size() == FDEPTH) && !do_pop;
            if (do_pop) begin
                void'(q_row.pop_front()); void'(q_col.pop_front()); void'(q_win.pop_front());
                pops++;
            end
            if (push_now) begin
                if (drop) m_ovf = 1;
                else begin
                    q_row.push_back(nrow); q_col.push_back(ncol); q_win.push_back(nwin);
                end
            end
        end
    end

    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3) != 0;
                default: out_ready = 1'b0;
            endcase
        end
    end

    function automatic bit hitf(input int kind, input int r, input int c);
        case (kind)
            1: return ((r == 0 || r == ROWS-1) && (c == 0 || c == COLS-1)) ||
                      (r == 1 && c == 2) || (r == 2 && c == COLS-1) ||
                      (r == ROWS-1 && c == 3) || (r == 1 && c == 0);
            2: return (r == 1 && c >= 1 && c <= 3) || (r == 2 && c == 2);
            3: return ((r * COLS + c) % 4) == 1;
            4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_frame(input int kind, input bit gaps, output int nh);
        int v, n, e;
        bit h;
        nh = 0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                v = ((r * 37 + c * 11 + kind * 29) % 256) - 128;
                h = hitf(kind, r, c);
                nh += int'(h);
                if (gaps && ((r + c) % 3 == 0)) begin
                    in_valid = 0; @(posedge clk); #1;
                end
                while (!in_ready) begin @(posedge clk); #1; end
                in_valid = 1; in_row = RW'(r); in_col = CW'(c); in_data = v[DW-1:0]; in_hit = h;
                @(posedge clk); #1;
                in_valid = 0; in_hit = 0;
                if (c == COLS - 1) begin
                    n = 0;
                    while (!in_ready) begin n++; @(posedge clk); #1; end
                    e = (r == ROWS - 1) ? COLS + 2 : 1;
                    if (r == ROWS - 1) chk(n == e, "R7 stall length", n, e);
                    else               chk(n == e, "R6 stall length", n, e);
                end
            end
    endtask

    task automatic drain();
        int k = 0;
        while ((q_row.size() > 0 || pend_v) && k < 200) begin @(posedge clk); #1; k++; end
        repeat (3) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int nh;
        rst_n = 0; in_valid = 0; in_hit = 0; in_row = '0; in_col = '0; in_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        model_on = 1;
        @(negedge clk); #1;
        chk(in_ready == 1, "R1 reset in_ready", in_ready, 1);
        chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
        chk(overflow == 0, "R1 reset overflow", overflow, 0);
        @(posedge clk); #1;

        pops = 0; run_frame(0, 0, nh); drain();
        chk(pops == 0, "R2 no hits no records", pops, 0);

        pops = 0; run_frame(1, 1, nh); drain();
        chk(pops == nh, "R2 R4 edge hit records", pops, nh);

        pops = 0; run_frame(2, 0, nh); drain();
        chk(pops == nh, "R5 adjacent hit records", pops, nh);

        rdy_mode = 1;
        pops = 0; run_frame(3, 1, nh); drain();
        chk(pops == nh, "R9 throttled records", pops, nh);
        chk(overflow == 0, "R10 no overflow when drained", overflow, 0);

        rdy_mode = 2;
        pops = 0; run_frame(4, 0, nh);
        repeat (5) begin @(posedge clk); #1; end
        chk(overflow == 1, "R10 overflow set", overflow, 1);
        rdy_mode = 0;
        drain();
        chk(pops == FDEPTH, "R10 kept records", pops, FDEPTH);
        chk(overflow == 1, "R10 overflow sticky", overflow, 1);

        finish_run();
    end

endmodule